// File: doc/BRIEF.md
# Multi-core external interrupt distributor

This block takes a set of level-sensitive external interrupt lines and fans each one out to the interrupt pins of a group of processor cores. A routing register is kept for every line. It holds one bit per core, and each set bit sends the line to that core.

Two global masks act on every line. The enable mask gates the external level. The software-assert mask forces a line active whatever its input. Each mask has one address for clearing bits and another for setting them. A write changes only the bits whose data bit is 1, so separate agents can change their own lines without a read-modify-write.

For every core the block works out which lines are live and routed to it. It drives that vector from a register onto the core's pins, moved up by a fixed offset. The pins below the offset belong to inter-processor interrupt logic outside this block. Line 0 has no external input and can only be raised by software. Configuration goes through a single-cycle request port with valid/ready handshaking. Ready is always high. A read answers on the next cycle with a response strobe, and the response cannot be back-pressured.

Top module: `irq_distributor`

## Requirements
- R1: For each core c, the live line vector is ((external levels AND enable mask) OR software-assert mask) AND the set of lines whose routing register has bit c set.
- R2: Live line i of core c drives bit i+2 of that core's pin slice, so core c's slice is bits [c*10+9:c*10] with the default parameters. Pins 0 and 1 of every slice are driven low.
- R3: The routing register of line i sits at word address i, for i from 0 to 7 with the default parameters. Only data bits [3:0] are stored, and bit k routes the line to core k. A read returns the stored bitmap with all higher bits zero.
- R4: A write to address 0x40 clears every enable bit whose data bit is 1. A write to address 0x41 sets every enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value.
- R5: Address 0x42 clears and address 0x43 sets software-assert bits, with the same write-one rule as R4.
- R6: After reset, every implemented line is enabled (reads 0xFF), the software-assert mask is zero, every routing register reads 1, and all pins are low.
- R7: Line 0 has no external input. It becomes active only through its software-assert bit.
- R8: A read accepted at one clock edge raises rsp_valid for exactly one cycle after that edge. Reads of 0x40 or 0x41 return the enable mask, and reads of 0x42 or 0x43 return the software-assert mask.
- R9: Writes to routing addresses of unimplemented lines (8 to 31) change no register. Reads of those addresses, and of every other unmapped address, return zero.
- R10: The pins change one clock edge after an external level changes. After a register write, the new state shows on the pins at the second clock edge following the write.
- R11: cfg_ready is high whenever the block is out of reset, so every request with cfg_valid high is accepted at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NUM_LINES-1 | External levels for lines 1 and up (bit i is line i) |
| cfg_valid | input | 1 | Register request present |
| cfg_ready | output | 1 | Request accepted (always high) |
| cfg_write | input | 1 | 1 for write, 0 for read |
| cfg_addr | input | 8 | Word address |
| cfg_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_rdata | output | 32 | Read data |
| core_irq | output | NUM_CORES*(NUM_LINES+2) | Per-core interrupt pins, with core c in slice c |

## Verification
The assertions assume that the external levels are already synchronous to clk. They also assume that cfg_addr, cfg_write and cfg_wdata hold known values whenever cfg_valid is high. The bench meets both conditions by driving every input at the falling edge, from a single stimulus thread, and by issuing one request per transaction with cfg_valid dropped in between. It sweeps all 128 external level patterns under several routing and mask setups. It also times the pin updates against the write cycle.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned ROUTE_SPAN = 32;

  localparam logic [ADDR_W-1:0] A_ENA_CLR  = 8'h40;
  localparam logic [ADDR_W-1:0] A_ENA_SET  = 8'h41;
  localparam logic [ADDR_W-1:0] A_ASRT_CLR = 8'h42;
  localparam logic [ADDR_W-1:0] A_ASRT_SET = 8'h43;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ROUTE,
    OP_ENA_CLR,
    OP_ENA_SET,
    OP_ASRT_CLR,
    OP_ASRT_SET
  } op_e;

  function automatic op_e decode_op(input logic [ADDR_W-1:0] a);
    if (a < ADDR_W'(ROUTE_SPAN)) return OP_ROUTE;
    case (a)
      A_ENA_CLR:  return OP_ENA_CLR;
      A_ENA_SET:  return OP_ENA_SET;
      A_ASRT_CLR: return OP_ASRT_CLR;
      A_ASRT_SET: return OP_ASRT_SET;
      default:    return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irqd_regs.sv
module irqd_regs
  import irqd_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_fire,
  input  logic                           acc_write,
  input  logic [ADDR_W-1:0]              acc_addr,
  input  logic [DATA_W-1:0]              acc_wdata,
  output logic [NUM_LINES-1:0]           ena_q,
  output logic [NUM_LINES-1:0]           asrt_q,
  output logic [NUM_LINES*NUM_CORES-1:0] route_q,
  output logic                           rsp_valid,
  output logic [DATA_W-1:0]              rsp_rdata
);
  localparam logic [NUM_LINES-1:0] ALL_LINES = '1;
  localparam logic [NUM_CORES-1:0] CORE0_ONLY = NUM_CORES'(1);

  op_e                  op;
  logic                 wr_fire;
  logic                 rd_fire;
  logic [NUM_LINES-1:0] wbits;
  logic [DATA_W-1:0]    rd_mux;

  assign op      = decode_op(acc_addr);
  assign wr_fire = acc_fire && acc_write;
  assign rd_fire = acc_fire && !acc_write;
  assign wbits   = acc_wdata[NUM_LINES-1:0];

  generate
    if (NUM_LINES < DATA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^acc_wdata[DATA_W-1:NUM_LINES];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q  <= ALL_LINES;
      asrt_q <= '0;
    end else if (wr_fire) begin
      case (op)
        OP_ENA_CLR:  ena_q  <= ena_q & ~wbits;
        OP_ENA_SET:  ena_q  <= ena_q | wbits;
        OP_ASRT_CLR: asrt_q <= asrt_q & ~wbits;
        OP_ASRT_SET: asrt_q <= asrt_q | wbits;
        default: ;
      endcase
    end
  end

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      logic [NUM_CORES-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= CORE0_ONLY;
        else if (wr_fire && op == OP_ROUTE && acc_addr == ADDR_W'(l))
          r <= acc_wdata[NUM_CORES-1:0];
      end
      assign route_q[l*NUM_CORES +: NUM_CORES] = r;
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (op)
      OP_ROUTE: begin
        for (int l = 0; l < NUM_LINES; l++) begin
          if (acc_addr == ADDR_W'(l))
            rd_mux = DATA_W'(route_q[l*NUM_CORES +: NUM_CORES]);
        end
      end
      OP_ENA_CLR, OP_ENA_SET:   rd_mux = DATA_W'(ena_q);
      OP_ASRT_CLR, OP_ASRT_SET: rd_mux = DATA_W'(asrt_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_fire;
      rsp_rdata <= rd_fire ? rd_mux : '0;
    end
  end

  // R4
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_addr == A_ENA_SET) |=>
      ((ena_q & $past(wbits)) == $past(wbits)));

  // R4
  ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_addr == A_ENA_CLR) |=> ((ena_q & $past(wbits)) == '0));

  // R5
  asrt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_addr == A_ASRT_SET) |=>
      ((asrt_q & $past(wbits)) == $past(wbits)));

  // R5
  asrt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_addr == A_ASRT_CLR) |=> ((asrt_q & $past(wbits)) == '0));

  // R9
  dead_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && acc_addr < ADDR_W'(ROUTE_SPAN) && acc_addr >= ADDR_W'(NUM_LINES))
      |=> $stable(route_q));

  // R8
  rsp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);
endmodule

// File: rtl/irqd_transpose.sv
module irqd_transpose #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [NUM_LINES*NUM_CORES-1:0] by_line,
  output logic [NUM_CORES*NUM_LINES-1:0] by_core
);
  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign by_core[c*NUM_LINES + l] = by_line[l*NUM_CORES + c];
      end
    end
  endgenerate
endmodule

// File: rtl/irqd_core_out.sv
module irqd_core_out #(
  parameter  int unsigned NUM_LINES = 8,
  parameter  int unsigned PIN_SHIFT = 2,
  localparam int unsigned PIN_W     = NUM_LINES + PIN_SHIFT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] armed,
  input  logic [NUM_LINES-1:0] col,
  output logic [PIN_W-1:0]     pins
);
  always_ff @(posedge clk) begin
    if (!rst_n) pins <= '0;
    else        pins <= {armed & col, {PIN_SHIFT{1'b0}}};
  end

  // R1
  unrouted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col == '0) |=> (pins[PIN_W-1:PIN_SHIFT] == '0));

  // R10
  routed_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((armed & col) != '0) |=> (pins[PIN_W-1:PIN_SHIFT] != '0));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
  import irqd_pkg::*;
#(
  parameter  int unsigned NUM_LINES = 8,
  parameter  int unsigned NUM_CORES = 4,
  parameter  int unsigned PIN_SHIFT = 2,
  localparam int unsigned PIN_W     = NUM_LINES + PIN_SHIFT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:1]       ext_irq,
  input  logic                       cfg_valid,
  output logic                       cfg_ready,
  input  logic                       cfg_write,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W-1:0]          cfg_wdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic [NUM_CORES*PIN_W-1:0] core_irq
);
  logic [NUM_LINES-1:0]           ena;
  logic [NUM_LINES-1:0]           asrt;
  logic [NUM_LINES*NUM_CORES-1:0] route_by_line;
  logic [NUM_CORES*NUM_LINES-1:0] route_by_core;
  logic [NUM_LINES-1:0]           levels;
  logic [NUM_LINES-1:0]           armed;

  assign cfg_ready = 1'b1;
  assign levels    = {ext_irq, 1'b0};
  assign armed     = (levels & ena) | asrt;

  irqd_regs #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_fire  (cfg_valid && cfg_ready),
    .acc_write (cfg_write),
    .acc_addr  (cfg_addr),
    .acc_wdata (cfg_wdata),
    .ena_q     (ena),
    .asrt_q    (asrt),
    .route_q   (route_by_line),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  irqd_transpose #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_xpose (
    .by_line (route_by_line),
    .by_core (route_by_core)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      irqd_core_out #(.NUM_LINES(NUM_LINES), .PIN_SHIFT(PIN_SHIFT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .col   (route_by_core[c*NUM_LINES +: NUM_LINES]),
        .pins  (core_irq[c*PIN_W +: PIN_W])
      );
    end
  endgenerate

  // R7
  line0_soft_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!asrt[0]) |-> (!armed[0]));
endmodule

// File: tb/irq_distributor_tb.sv
module irq_distributor_tb;
  localparam int CLK_P = 10;
  localparam int NL    = 8;
  localparam int NC    = 4;
  localparam int PW    = NL + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:1] ext_irq = '0;
  logic          cfg_valid = 1'b0;
  logic          cfg_ready;
  logic          cfg_write = 1'b0;
  logic [7:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NC*PW-1:0] core_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [NL-1:0] m_ena;
  logic [NL-1:0] m_asrt;
  logic [NC-1:0] m_route [NL];
  logic [NL-1:1] m_ext;

  always #(CLK_P/2) clk = ~clk;

  irq_distributor u_dut (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_write(cfg_write),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .core_irq(core_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [PW-1:0] exp_pins(input int c);
    logic [NL-1:0] lv;
    logic [NL-1:0] act;
    lv = {m_ext, 1'b0};
    for (int l = 0; l < NL; l++)
      act[l] = ((lv[l] & m_ena[l]) | m_asrt[l]) & m_route[l][c];
    return {act, 2'b00};
  endfunction

  task automatic pins_all(input string req);
    for (int c = 0; c < NC; c++)
      chk(req, 32'(core_irq[c*PW +: PW]), 32'(exp_pins(c)));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d;
    chk("R11 ready", 32'(cfg_ready), 32'd1);
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
    if (a < 8'(NL)) m_route[a] = d[NC-1:0];
    else if (a == 8'h40) m_ena  = m_ena  & ~d[NL-1:0];
    else if (a == 8'h41) m_ena  = m_ena  |  d[NL-1:0];
    else if (a == 8'h42) m_asrt = m_asrt & ~d[NL-1:0];
    else if (a == 8'h43) m_asrt = m_asrt |  d[NL-1:0];
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a;
    @(negedge clk);
    cfg_valid = 1'b0;
    chk("R8 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(req, rsp_rdata, exp);
    @(negedge clk);
    chk("R8 one-cycle strobe", 32'(rsp_valid), 32'd0);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 128; v++) begin
      @(negedge clk);
      ext_irq = 7'(v); m_ext = 7'(v);
      @(negedge clk);
      pins_all(req);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired got=running exp=finished");
    finish_run();
  end

  initial begin
    logic [PW-1:0] before0;
    m_ena = '1; m_asrt = '0; m_ext = '0;
    for (int l = 0; l < NL; l++) m_route[l] = 4'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R6: reset state
    pins_all("R6 reset pins");
    for (int l = 0; l < NL; l++) rd(8'(l), 32'd1, "R6 route reset");
    rd(8'h40, 32'hFF, "R6 enable reset");
    rd(8'h43, 32'h00, "R6 assert reset");

    // R9: dead routing slots and unmapped addresses
    wr(8'h09, 32'hFFFF_FFFF);
    wr(8'h1F, 32'h0000_000F);
    rd(8'h09, 32'd0, "R9 dead route read");
    rd(8'h1F, 32'd0, "R9 dead route read");
    rd(8'h20, 32'd0, "R9 unmapped read");
    rd(8'h44, 32'd0, "R9 unmapped read");
    rd(8'hFF, 32'd0, "R9 unmapped read");
    for (int l = 0; l < NL; l++) rd(8'(l), 32'd1, "R9 routes untouched");

    // R1 R2 R7: default routing, all external patterns
    sweep("R1 R2 R7 reset config");

    // R3: varied routing with junk above the core bits
    for (int l = 0; l < NL; l++) wr(8'(l), 32'hABCD_EF00 | 32'((l*5 + 3) & 15));
    for (int l = 0; l < NL; l++) rd(8'(l), 32'((l*5 + 3) & 15), "R3 route readback");

    // R4 R5: write-one clear and set
    wr(8'h40, 32'h0000_000F);
    rd(8'h40, 32'hF0, "R4 enable clear");
    rd(8'h41, 32'hF0, "R8 enable alias");
    wr(8'h43, 32'h0000_0003);
    rd(8'h42, 32'h03, "R5 assert set");
    sweep("R1 R7 masked config");

    wr(8'h41, 32'h0000_0005);
    rd(8'h41, 32'hF5, "R4 enable set");
    wr(8'h42, 32'h0000_0001);
    rd(8'h43, 32'h02, "R5 assert clear");
    wr(8'h42, 32'h0000_0000);
    rd(8'h42, 32'h02, "R5 zero write no effect");
    sweep("R1 R2 second config");

    // R10: write-to-pin latency
    wr(8'h43, 32'h0);
    @(negedge clk);
    ext_irq = '0; m_ext = '0;
    wr(8'h03, 32'h1);
    @(negedge clk);
    before0 = exp_pins(0);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = 8'h43; cfg_wdata = 32'h08;
    @(negedge clk);
    cfg_valid = 1'b0; cfg_write = 1'b0;
    chk("R10 pins hold one edge after write", 32'(core_irq[PW-1:0]), 32'(before0));
    m_asrt = m_asrt | 8'h08;
    @(negedge clk);
    chk("R10 pins update second edge", 32'(core_irq[PW-1:0]), 32'(exp_pins(0)));
    pins_all("R10 all cores");

    // R7: line 0 via software only, broad routing
    wr(8'h41, 32'hFF);
    wr(8'h42, 32'hFF);
    wr(8'h00, 32'hF);
    wr(8'h02, 32'hF);
    sweep("R7 line0 idle");
    wr(8'h43, 32'h01);
    @(negedge clk);
    pins_all("R7 line0 soft assert");

    finish_run();
  end
endmodule